// File: doc/BRIEF.md
# Character Text Overlay Mixer

This block lays a text screen of 40 columns by 25 rows over an outgoing YCrCb video stream. Each pixel enters with a valid strobe, a start-of-field marker and a field flag. The block works out where that pixel sits on the screen. It then replaces the pixel with a text colour or a background colour, or lets it through unchanged. The decision depends on the character code stored for that screen cell and on one bit of that character's glyph pattern.

A single write port loads everything the block uses. That is the character buffer, the 128-entry glyph pattern memory, the text and background colours, and a raster mode word. The mode word sets the active pixels per line, the active lines per frame, and whether the video is interlaced. In interlaced video each glyph row is chosen from the frame line, so every character shows in both fields.

The glyphs are 8 by 8 bits. Each glyph bit covers a 2 by 2 block of output pixels, so the text screen covers the top-left 640 by 400 pixels of the active picture. The mixer delays the pixel and its qualifiers by a fixed two clock cycles.

Top module: `text_overlay_mixer`

## Requirements
- R1: After reset the output valid, sync flags and pixel are all zero. The raster mode is 720 pixels per line, 576 lines per frame, interlaced. The text colour is Y=235 Cr=128 Cb=128 and the background colour is Y=16 Cr=128 Cb=128.
- R2: Every input pixel with `vin_valid` high appears on the outputs exactly two clock cycles later. `vout_sof` and `vout_field` carry the values that came in with that pixel.
- R3: A cell holding code 0 passes the incoming pixel through unchanged.
- R4: A code from 1 to 127 is transparent. Where its glyph bit is 1 the output is the text colour; where the bit is 0 the incoming pixel passes through.
- R5: A code from 128 to 255 uses glyph (code & 127). Where the glyph bit is 1 the output is the text colour; where it is 0 the output is the background colour.
- R6: A pixel with column 640 or higher, or with frame line 400 or higher, passes through unchanged.
- R7: Screen geometry. Cell address = (frame_line/16)*40 + column/16. Glyph byte address = glyph*8 + (frame_line/2)%8. The glyph bit is bit 7-(column/2)%8 of that byte, so bit 7 is the leftmost pixel.
- R8: The pixel marked by `vin_sof` is column 0, line 0. The column wraps to 0 after pixel (pixels_per_line - 1), and the line then advances. The line wraps to 0 after the last line of the field. A field has lines_per_frame lines in progressive mode and lines_per_frame/2 lines in interlaced mode.
- R9: In interlaced mode frame_line = 2*field_line + `vin_field`. In progressive mode frame_line = field_line and `vin_field` does not change the picture.
- R10: A write with `cfg_we` high stores data according to `cfg_sel`.
  - 0: the character code `cfg_wdata[7:0]` at cell `cfg_addr`.
  - 1: the glyph byte `cfg_wdata[7:0]` at glyph address `cfg_addr`.
  - 2: one colour byte `cfg_wdata[7:0]`. `cfg_addr` 0, 1, 2 select text Y, Cr, Cb; 3, 4, 5 select background Y, Cr, Cb.
  - 3: the mode word, with pixels per line in bits 9:0, lines per frame in bits 21:12, and bit 31 = 1 for progressive, 0 for interlaced.
- R11: A cycle with `vin_valid` low does not move the raster position. Two cycles later it gives `vout_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_we | input | 1 | configuration write strobe |
| cfg_sel | input | 2 | write target select |
| cfg_addr | input | 10 | write address within the target |
| cfg_wdata | input | 32 | write data |
| vin_valid | input | 1 | input pixel valid |
| vin_sof | input | 1 | first pixel of a field |
| vin_field | input | 1 | field of the input pixel |
| vin_y | input | 8 | input luma |
| vin_cr | input | 8 | input red chroma |
| vin_cb | input | 8 | input blue chroma |
| vout_valid | output | 1 | output pixel valid |
| vout_sof | output | 1 | delayed start-of-field |
| vout_field | output | 1 | delayed field flag |
| vout_y | output | 8 | output luma |
| vout_cr | output | 8 | output red chroma |
| vout_cb | output | 8 | output blue chroma |

## Verification
The bench builds the block with its default parameters: 40 by 25 cells, 8 by 8 glyphs, double-size pixels and 10-bit raster counters. It reaches the edges of the text area by programming the raster instead of changing the geometry. A 660-pixel line crosses the right edge at column 640. A 20-pixel by 410-line progressive frame crosses the bottom edge at line 400. A 4-line field shows the line wrap. Fields of an interlaced 48-line frame, with idle cycles mixed in, exercise the frame-line interleave and stalls. A run left in the reset mode shows the 720-pixel line wrap.

// File: rtl/olay_pkg.sv
package olay_pkg;

  localparam logic [1:0] SEL_CHAR   = 2'd0;
  localparam logic [1:0] SEL_GLYPH  = 2'd1;
  localparam logic [1:0] SEL_COLOUR = 2'd2;
  localparam logic [1:0] SEL_MODE   = 2'd3;

  typedef struct packed {
    logic [7:0] y;
    logic [7:0] cr;
    logic [7:0] cb;
  } ycc_t;

  typedef enum logic [1:0] {
    MIX_VIDEO = 2'd0,
    MIX_INK   = 2'd1,
    MIX_BOX   = 2'd2
  } mix_e;

  // source choice for one pixel
  function automatic mix_e mix_pick(input logic in_area, input logic [7:0] code,
                                    input logic gbit);
    if (!in_area || code == 8'd0) return MIX_VIDEO;
    if (gbit)                     return MIX_INK;
    if (code[7])                  return MIX_BOX;
    return MIX_VIDEO;
  endfunction

  // line index within the whole frame
  function automatic logic [15:0] frame_line(input logic [15:0] fld_line,
                                             input logic field, input logic prog);
    return prog ? fld_line : {fld_line[14:0], field};
  endfunction

endpackage

// File: rtl/olay_ram.sv
module olay_ram #(
  parameter int W         = 8,
  parameter int DEPTH     = 1024,
  parameter int AW        = 10,
  parameter bit SYNC_READ = 1'b1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_raw;

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  assign rd_raw = (32'(raddr) < DEPTH) ? mem[raddr] : '0;

  generate
    if (SYNC_READ) begin : g_sync
      logic [W-1:0] rd_q;
      always_ff @(posedge clk) rd_q <= rd_raw;
      assign rdata = rd_q;
    end else begin : g_async
      assign rdata = rd_raw;
    end
  endgenerate
endmodule

// File: rtl/olay_raster.sv
module olay_raster #(
  parameter int XW = 10,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          pix_sof,
  input  logic          pix_field,
  input  logic [XW-1:0] ppl,
  input  logic [LW-1:0] lpd,
  input  logic          progressive,
  output logic [XW-1:0] cur_x,
  output logic [LW-1:0] frame_ln,
  output logic [XW-1:0] nxt_x,
  output logic [LW-1:0] nxt_l,
  output logic          line_end,
  output logic          field_end
);
  import olay_pkg::*;

  logic [XW-1:0] x_q;
  logic [LW-1:0] l_q;
  logic [LW-1:0] cur_l;
  logic [LW-1:0] field_lines;

  assign cur_x       = pix_sof ? '0 : x_q;
  assign cur_l       = pix_sof ? '0 : l_q;
  assign field_lines = progressive ? lpd : (lpd >> 1);
  assign line_end    = (cur_x >= ppl - XW'(1));
  assign field_end   = line_end && (cur_l >= field_lines - LW'(1));
  assign frame_ln    = LW'(frame_line(16'(cur_l), pix_field, progressive));
  assign nxt_x       = x_q;
  assign nxt_l       = l_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      l_q <= '0;
    end else if (pix_valid) begin
      if (line_end) begin
        x_q <= '0;
        l_q <= field_end ? '0 : cur_l + LW'(1);
      end else begin
        x_q <= cur_x + XW'(1);
        l_q <= cur_l;
      end
    end
  end
endmodule

// File: rtl/olay_mix.sv
module olay_mix #(
  parameter int GW   = 8,
  parameter int GC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_field,
  input  olay_pkg::ycc_t   video,
  input  logic             in_area,
  input  logic [7:0]       code,
  input  logic [GW-1:0]    gbyte,
  input  logic [GC_W-1:0]  gcol,
  input  olay_pkg::ycc_t   ink,
  input  olay_pkg::ycc_t   box,
  output logic             gbit,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_field,
  output olay_pkg::ycc_t   out_pix
);
  import olay_pkg::*;

  mix_e pick;

  assign gbit = gbyte[GC_W'(GW - 1) - gcol];
  assign pick = mix_pick(in_area, code, gbit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_field <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      out_sof   <= in_sof;
      out_field <= in_field;
      unique case (pick)
        MIX_INK: out_pix <= ink;
        MIX_BOX: out_pix <= box;
        default: out_pix <= video;
      endcase
    end
  end
endmodule

// File: rtl/text_overlay_mixer.sv
module text_overlay_mixer #(
  parameter int COLS   = 40,
  parameter int ROWS   = 25,
  parameter int GW     = 8,
  parameter int GH     = 8,
  parameter int SCALE  = 2,
  parameter int XW     = 10,
  parameter int LW     = 10,
  parameter int CFG_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              vin_valid,
  input  logic              vin_sof,
  input  logic              vin_field,
  input  logic [7:0]        vin_y,
  input  logic [7:0]        vin_cr,
  input  logic [7:0]        vin_cb,
  output logic              vout_valid,
  output logic              vout_sof,
  output logic              vout_field,
  output logic [7:0]        vout_y,
  output logic [7:0]        vout_cr,
  output logic [7:0]        vout_cb
);
  import olay_pkg::*;

  localparam int CELL_W = GW * SCALE;
  localparam int CELL_H = GH * SCALE;
  localparam int AREA_W = COLS * CELL_W;
  localparam int AREA_H = ROWS * CELL_H;
  localparam int CHARS  = COLS * ROWS;
  localparam int CA_W   = $clog2(CHARS);
  localparam int GLYPHS = 128;
  localparam int GC_W   = $clog2(GW);
  localparam int GR_W   = $clog2(GH);
  localparam int GDEPTH = GLYPHS * GH;
  localparam int GA_W   = 7 + GR_W;

  // configuration state
  logic [XW-1:0] ppl_q;
  logic [LW-1:0] lpd_q;
  logic          prog_q;
  ycc_t          ink_q, box_q;
  logic          unused_cfg;

  assign unused_cfg = ^{cfg_wdata[30:22], cfg_wdata[11:10]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ppl_q  <= XW'(720);
      lpd_q  <= LW'(576);
      prog_q <= 1'b0;
      ink_q  <= '{y: 8'd235, cr: 8'd128, cb: 8'd128};
      box_q  <= '{y: 8'd16,  cr: 8'd128, cb: 8'd128};
    end else if (cfg_we) begin
      if (cfg_sel == SEL_MODE) begin
        ppl_q  <= XW'(cfg_wdata[9:0]);
        lpd_q  <= LW'(cfg_wdata[21:12]);
        prog_q <= cfg_wdata[31];
      end else if (cfg_sel == SEL_COLOUR) begin
        case (cfg_addr[2:0])
          3'd0: ink_q.y  <= cfg_wdata[7:0];
          3'd1: ink_q.cr <= cfg_wdata[7:0];
          3'd2: ink_q.cb <= cfg_wdata[7:0];
          3'd3: box_q.y  <= cfg_wdata[7:0];
          3'd4: box_q.cr <= cfg_wdata[7:0];
          3'd5: box_q.cb <= cfg_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  // stage 0: raster position and cell decode
  logic [XW-1:0] cur_x, rast_nxt_x;
  logic [LW-1:0] fline, rast_nxt_l;
  logic          rast_line_end, rast_field_end;

  olay_raster #(.XW(XW), .LW(LW)) u_raster (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(vin_valid), .pix_sof(vin_sof), .pix_field(vin_field),
    .ppl(ppl_q), .lpd(lpd_q), .progressive(prog_q),
    .cur_x(cur_x), .frame_ln(fline), .nxt_x(rast_nxt_x), .nxt_l(rast_nxt_l),
    .line_end(rast_line_end), .field_end(rast_field_end)
  );

  logic            s0_area;
  logic [CA_W-1:0] s0_cell;
  logic [GC_W-1:0] s0_gcol;
  logic [GR_W-1:0] s0_grow;

  assign s0_area = (32'(cur_x) < AREA_W) && (32'(fline) < AREA_H);
  assign s0_cell = CA_W'((32'(fline) / CELL_H) * COLS + 32'(cur_x) / CELL_W);
  assign s0_gcol = GC_W'((32'(cur_x) % CELL_W) / SCALE);
  assign s0_grow = GR_W'((32'(fline) % CELL_H) / SCALE);

  // character buffer, registered read forms stage 1
  logic [7:0] s1_code;

  olay_ram #(.W(8), .DEPTH(CHARS), .AW(CA_W), .SYNC_READ(1'b1)) u_chars (
    .clk(clk), .we(cfg_we && cfg_sel == SEL_CHAR),
    .waddr(CA_W'(cfg_addr)), .wdata(cfg_wdata[7:0]),
    .raddr(s0_cell), .rdata(s1_code)
  );

  logic            s1_valid, s1_sof, s1_field, s1_area;
  ycc_t            s1_pix;
  logic [GC_W-1:0] s1_gcol;
  logic [GR_W-1:0] s1_grow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sof   <= 1'b0;
      s1_field <= 1'b0;
      s1_area  <= 1'b0;
      s1_pix   <= '0;
      s1_gcol  <= '0;
      s1_grow  <= '0;
    end else begin
      s1_valid <= vin_valid;
      s1_sof   <= vin_sof && vin_valid;
      s1_field <= vin_field;
      s1_area  <= s0_area;
      s1_pix   <= '{y: vin_y, cr: vin_cr, cb: vin_cb};
      s1_gcol  <= s0_gcol;
      s1_grow  <= s0_grow;
    end
  end

  // glyph pattern memory, combinational read in stage 1
  logic [GW-1:0] s1_gbyte;

  olay_ram #(.W(GW), .DEPTH(GDEPTH), .AW(GA_W), .SYNC_READ(1'b0)) u_glyphs (
    .clk(clk), .we(cfg_we && cfg_sel == SEL_GLYPH),
    .waddr(GA_W'(cfg_addr)), .wdata(GW'(cfg_wdata[7:0])),
    .raddr({s1_code[6:0], s1_grow}), .rdata(s1_gbyte)
  );

  // stage 2: selection and output register
  logic s1_gbit;
  ycc_t out_pix;

  olay_mix #(.GW(GW), .GC_W(GC_W)) u_mix (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s1_valid), .in_sof(s1_sof), .in_field(s1_field),
    .video(s1_pix), .in_area(s1_area), .code(s1_code),
    .gbyte(s1_gbyte), .gcol(s1_gcol), .ink(ink_q), .box(box_q),
    .gbit(s1_gbit), .out_valid(vout_valid), .out_sof(vout_sof),
    .out_field(vout_field), .out_pix(out_pix)
  );

  assign vout_y  = out_pix.y;
  assign vout_cr = out_pix.cr;
  assign vout_cb = out_pix.cb;
endmodule

// File: rtl/olay_checks.sv
module olay_checks #(
  parameter int XW = 10,
  parameter int LW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           vin_valid,
  input logic           vin_sof,
  input logic [XW-1:0]  ppl,
  input logic [XW-1:0]  nxt_x,
  input logic [LW-1:0]  nxt_l,
  input logic           line_end,
  input logic           s1_valid,
  input logic           s1_area,
  input logic [7:0]     s1_code,
  input logic           s1_gbit,
  input olay_pkg::ycc_t s1_pix,
  input olay_pkg::ycc_t ink,
  input olay_pkg::ycc_t box,
  input logic           vout_valid,
  input logic [7:0]     vout_y,
  input logic [7:0]     vout_cr,
  input logic [7:0]     vout_cb
);
  logic [23:0] vout_pix;
  assign vout_pix = {vout_y, vout_cr, vout_cb};

  AST_PIPE_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    vin_valid |=> s1_valid); // R2
  AST_PIPE_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> vout_valid); // R2
  AST_BUBBLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !vout_valid); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vin_valid |=> ($stable(nxt_x) && $stable(nxt_l))); // R11
  AST_BLANK_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_area && s1_code == 8'd0) |=> vout_pix == $past(s1_pix)); // R3
  AST_GLYPH_INK: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_area && s1_code != 8'd0 && s1_gbit) |=> vout_pix == $past(ink)); // R4
  AST_BOX_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_area && s1_code[7] && !s1_gbit) |=> vout_pix == $past(box)); // R5
  AST_OUTSIDE_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_area) |=> vout_pix == $past(s1_pix)); // R6
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (vin_valid && line_end) |=> nxt_x == '0); // R8
  AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (vin_valid && vin_sof && ppl > XW'(1)) |=> nxt_x == XW'(1)); // R8
endmodule

bind text_overlay_mixer olay_checks #(.XW(XW), .LW(LW)) u_olay_checks (
  .clk(clk), .rst_n(rst_n), .vin_valid(vin_valid), .vin_sof(vin_sof),
  .ppl(ppl_q), .nxt_x(rast_nxt_x), .nxt_l(rast_nxt_l), .line_end(rast_line_end),
  .s1_valid(s1_valid), .s1_area(s1_area), .s1_code(s1_code), .s1_gbit(s1_gbit),
  .s1_pix(s1_pix), .ink(ink_q), .box(box_q), .vout_valid(vout_valid),
  .vout_y(vout_y), .vout_cr(vout_cr), .vout_cb(vout_cb)
);

// File: tb/test_text_overlay_mixer.sv
module test_text_overlay_mixer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [9:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        vin_valid = 1'b0, vin_sof = 1'b0, vin_field = 1'b0;
  logic [7:0]  vin_y = '0, vin_cr = '0, vin_cb = '0;
  logic        vout_valid, vout_sof, vout_field;
  logic [7:0]  vout_y, vout_cr, vout_cb;

  always #(CLK_PERIOD / 2) clk = ~clk;

  text_overlay_mixer i_text_overlay_mixer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .vin_valid(vin_valid),
    .vin_sof(vin_sof), .vin_field(vin_field), .vin_y(vin_y), .vin_cr(vin_cr),
    .vin_cb(vin_cb), .vout_valid(vout_valid), .vout_sof(vout_sof),
    .vout_field(vout_field), .vout_y(vout_y), .vout_cr(vout_cr), .vout_cb(vout_cb)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0]  chars [1000];
  logic [7:0]  glyphs [1024];
  logic [23:0] ink = 24'hEB8080;
  logic [23:0] box = 24'h108080;
  logic [25:0] exp_q [$];
  int          tag_q [$];
  int          scen_q [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model written from the requirements (R3..R7, R9)
  function automatic logic [23:0] model(input int x, input int fl, input logic [23:0] video,
                                        output int tag);
    int code, g, b;
    if (x >= 640 || fl >= 400) begin tag = 6; return video; end
    code = int'(chars[(fl / 16) * 40 + x / 16]);
    if (code == 0) begin tag = 3; return video; end
    g = int'(glyphs[(code % 128) * 8 + (fl / 2) % 8]);
    b = (g >> (7 - (x / 2) % 8)) & 1;
    tag = (code >= 128) ? 5 : 4;
    if (b == 1) return ink;
    return (code >= 128) ? box : video;
  endfunction

  // output collector: compares every valid output pixel in order
  always @(negedge clk) begin
    if (rst_n && vout_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected output pixel", {vout_y, vout_cr, vout_cb}, 0);
      end else begin
        automatic logic [25:0] e = exp_q.pop_front();
        automatic int t = tag_q.pop_front();
        automatic int s = scen_q.pop_front();
        automatic logic [25:0] a = {vout_sof, vout_field, vout_y, vout_cr, vout_cb};
        check(a == e, $sformatf("R%0d (scenario R%0d)", t, s), 32'(a), 32'(e));
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 10'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R10: mode word encoding
  task automatic set_mode(input int ppl, input int lpd, input bit prog);
    cfg_write(2'd3, 0, {prog, 9'd0, 10'(lpd), 2'd0, 10'(ppl)});
  endtask

  // drives lines without a new start marker, so wraps follow R8
  task automatic run_raster(input int ppl, input int total, input int fl_lines, input bit prog,
                            input bit field, input bit gaps, input int scen);
    for (int l = 0; l < total; l++) begin
      for (int x = 0; x < ppl; x++) begin
        automatic int fline = l % fl_lines;
        automatic int frl = prog ? fline : 2 * fline + int'(field);
        automatic logic [23:0] vid = {8'(x) ^ 8'(l), 8'(l * 3), 8'(x + 7)};
        automatic int tag;
        automatic logic [23:0] e = model(x, frl, vid, tag);
        @(negedge clk);
        vin_valid = 1'b1; vin_sof = (x == 0 && l == 0); vin_field = field;
        {vin_y, vin_cr, vin_cb} = vid;
        exp_q.push_back({vin_sof, field, e}); tag_q.push_back(tag); scen_q.push_back(scen);
        if (gaps && ((x + l) % 7 == 0)) begin
          @(negedge clk);
          vin_valid = 1'b0; vin_sof = 1'b0; {vin_y, vin_cr, vin_cb} = ~vid;
        end
      end
    end
    @(negedge clk);
    vin_valid = 1'b0; vin_sof = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 output count", exp_q.size(), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(vout_valid == 1'b0, "R1 valid at reset", vout_valid, 0);
    check({vout_sof, vout_field} == 2'b00, "R1 flags at reset", {vout_sof, vout_field}, 0);
    check({vout_y, vout_cr, vout_cb} == 24'h0, "R1 pixel at reset",
          {vout_y, vout_cr, vout_cb}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_load;
    for (int i = 0; i < 1000; i++) begin
      chars[i] = (i == 0) ? 8'd0 : 8'(i * 37 + 11);
      cfg_write(2'd0, i, {24'd0, chars[i]});
    end
    for (int a = 0; a < 1024; a++) begin
      glyphs[a] = 8'(a * 73 + (a >> 3) * 29 + 5);
      cfg_write(2'd1, a, {24'd0, glyphs[a]});
    end
  endtask

  // R1: reset mode is 720 pixels, interlaced, reset colours
  task automatic t_default_mode;
    run_raster(720, 3, 288, 1'b0, 1'b1, 1'b0, 1);
  endtask

  task automatic t_colours;
    ink = 24'hD25A10; box = 24'h2AB0F0;
    cfg_write(2'd2, 0, 32'hD2); cfg_write(2'd2, 1, 32'h5A); cfg_write(2'd2, 2, 32'h10);
    cfg_write(2'd2, 3, 32'h2A); cfg_write(2'd2, 4, 32'hB0); cfg_write(2'd2, 5, 32'hF0);
  endtask

  // R2: single pixel appears exactly two cycles later
  task automatic t_latency;
    automatic int tag;
    automatic logic [23:0] e;
    set_mode(24, 4, 1'b1);
    e = model(0, 0, 24'h123456, tag);
    @(negedge clk);
    vin_valid = 1'b1; vin_sof = 1'b1; vin_field = 1'b1; {vin_y, vin_cr, vin_cb} = 24'h123456;
    exp_q.push_back({2'b11, e}); tag_q.push_back(tag); scen_q.push_back(2);
    @(negedge clk);
    vin_valid = 1'b0; vin_sof = 1'b0; vin_field = 1'b0;
    check(vout_valid == 1'b0, "R2 valid one cycle after input", vout_valid, 0);
    @(negedge clk);
    check(vout_valid == 1'b1, "R2 valid two cycles after input", vout_valid, 1);
    check({vout_sof, vout_field} == 2'b11, "R2 delayed flags", {vout_sof, vout_field}, 3);
    @(negedge clk);
    check(vout_valid == 1'b0, "R11 idle cycle gives no output", vout_valid, 0);
  endtask

  initial begin
    t_reset();
    t_load();
    t_default_mode();                                    // R1 R8
    t_latency();                                         // R2 R11
    set_mode(660, 24, 1'b1);
    run_raster(660, 24, 24, 1'b1, 1'b1, 1'b0, 9);        // R9 progressive ignores field, R6 right edge
    t_colours();                                         // R10
    run_raster(660, 2, 24, 1'b1, 1'b0, 1'b0, 10);
    set_mode(24, 4, 1'b1);
    run_raster(24, 6, 4, 1'b1, 1'b0, 1'b0, 8);           // R8 line wrap
    set_mode(20, 410, 1'b1);
    run_raster(20, 410, 410, 1'b1, 1'b0, 1'b0, 7);       // R7 all rows, R6 bottom edge
    set_mode(660, 48, 1'b0);
    run_raster(660, 24, 24, 1'b0, 1'b0, 1'b1, 9);        // R9 field 0, R11 gaps
    run_raster(660, 24, 24, 1'b0, 1'b1, 1'b1, 11);       // R9 field 1
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule